// File: doc/BRIEF.md
# Page Table Address Translator

This block maps a 32-bit virtual address onto a 32-bit physical address through a single-level page table kept in external memory. A processor-side port hands in one request at a time. Each request carries a virtual address and a flag that marks it as a read or a write. A table-base register, loaded through its own write port, points at the table of the running process. For every request the block fetches one 4-byte entry from memory. It then checks that entry for presence and write permission, and returns either a physical address or a fault code.

Pages are 4 KB. The low 12 address bits pass through untouched as the page offset. The upper 20 bits select the entry, and the entry supplies the 20-bit frame number that replaces them. The result stays on the response port until the processor takes it. Only then does the block accept the next request.

Top module: `pt_xlate`

## Requirements
- R1: On a successful translation, bits 11:0 of `rsp_paddr` equal bits 11:0 of the accepted virtual address.
- R2: One cycle after a request is accepted, `mem_req` is high and `mem_addr` equals the table base plus four times the virtual page number (`vaddr[31:12]`), taken modulo 2^32.
- R3: On a successful translation, `rsp_paddr[31:12]` equals entry bits 31:12. Entry bits 11:2 have no effect on the result.
- R4: When entry bit 0 (present) is 0, the status is 2'b01 (page fault) and `rsp_paddr` is zero.
- R5: A write to a present entry whose bit 1 (writable) is 0 gives status 2'b10 (protection fault) and a zero `rsp_paddr`. A read of the same entry succeeds.
- R6: A present entry that passes the permission check gives status 2'b00. Status 2'b11 never appears.
- R7: `req_ready` is high after reset and whenever no translation is in flight. It is low from acceptance until the response is taken. While `rsp_valid` is high and `rsp_ready` is low, the response holds stable.
- R8: The table base resets to zero. A base write applies to requests accepted after it. A base write made while a translation is in flight does not change that translation's entry address.
- R9: Each translation raises `mem_req` for exactly one cycle, and `mem_req` never rises without an accepted request.
- R10: A write to an entry that is not present reports a page fault (2'b01), not a protection fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_we | input | 1 | Load strobe for the table-base register |
| base_wdata | input | 32 | New table base |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Processor takes the result |
| rsp_paddr | output | 32 | Physical address, zero on a fault |
| rsp_status | output | 2 | 00 ok, 01 page fault, 10 protection fault |
| mem_req | output | 1 | One-cycle entry read strobe |
| mem_addr | output | 32 | Byte address of the entry |
| mem_rvalid | input | 1 | Entry data valid |
| mem_rdata | input | 32 | Entry word |

## Verification
The hardest case to reach is a table-base write that arrives while an entry fetch is still outstanding. It must leave that fetch alone and steer only the next request. The bench creates it by holding the memory model's reply back for a chosen latency and writing the base inside that window. It then checks both the in-flight entry address and the following one. A sweep of page numbers, offsets and access types is run over three table bases, one of which makes the entry address wrap past 2^32. Replies come back with zero to three cycles of latency, and the processor stalls on the response for zero to two cycles. The sweep covers every fault combination, including a write to a missing page.

// File: rtl/ptx_pkg.sv
package ptx_pkg;
  typedef enum logic [1:0] {
    XS_OK         = 2'b00,
    XS_PAGE_FAULT = 2'b01,
    XS_PROT_FAULT = 2'b10
  } xlate_status_e;

  typedef enum logic [1:0] {
    FS_IDLE,
    FS_FETCH,
    FS_HOLD
  } fetch_state_e;
endpackage

// File: rtl/ptx_base_reg.sv
module ptx_base_reg #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] RESET_BASE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_data,
  output logic [ADDR_W-1:0] base_o
);
  always_ff @(posedge clk) begin
    if (rst)        base_o <= RESET_BASE;
    else if (wr_en) base_o <= wr_data;
  end

  AST_BASE_KEEP: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(base_o)); // R8
endmodule

// File: rtl/ptx_fetch_ctl.sv
module ptx_fetch_ctl
  import ptx_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int PAGE_W      = 12,
  parameter int ENTRY_SHIFT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_vaddr,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] table_base,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic              rsp_fire,
  output logic              result_load,
  output logic [PAGE_W-1:0] off_q,
  output logic              write_q
);
  localparam int VPN_W = ADDR_W - PAGE_W;

  fetch_state_e      state;
  logic [VPN_W-1:0]  vpn;
  logic [ADDR_W-1:0] entry_addr;
  logic              accept;

  assign vpn         = req_vaddr[ADDR_W-1:PAGE_W];
  assign entry_addr  = table_base + (ADDR_W'(vpn) << ENTRY_SHIFT);
  assign req_ready   = (state == FS_IDLE);
  assign accept      = req_valid && req_ready;
  assign result_load = (state == FS_FETCH) && mem_rvalid;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= FS_IDLE;
      mem_req  <= 1'b0;
      mem_addr <= '0;
      off_q    <= '0;
      write_q  <= 1'b0;
    end else begin
      mem_req <= 1'b0;
      case (state)
        FS_IDLE: begin
          if (accept) begin
            state    <= FS_FETCH;
            mem_req  <= 1'b1;
            mem_addr <= entry_addr;
            off_q    <= req_vaddr[PAGE_W-1:0];
            write_q  <= req_write;
          end
        end
        FS_FETCH: begin
          if (mem_rvalid) state <= FS_HOLD;
        end
        FS_HOLD: begin
          if (rsp_fire) state <= FS_IDLE;
        end
        default: state <= FS_IDLE;
      endcase
    end
  end

  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req); // R9
  AST_STROBE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req) |-> $past(req_valid && req_ready)); // R9
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    (state == FS_FETCH && !mem_req) |-> $stable(mem_addr)); // R2
endmodule

// File: rtl/ptx_entry_eval.sv
module ptx_entry_eval
  import ptx_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_W    = 12,
  parameter int PTE_W     = 32,
  parameter int VALID_BIT = 0,
  parameter int WRITE_BIT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [PTE_W-1:0]  pte,
  input  logic [PAGE_W-1:0] off,
  input  logic              is_write,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic [1:0]        rsp_status
);
  localparam int FRAME_W = ADDR_W - PAGE_W;

  logic [FRAME_W-1:0] frame;
  logic               present;
  logic               writable;
  logic               pte_unused;
  xlate_status_e      status_n;
  logic [ADDR_W-1:0]  paddr_n;

  assign frame      = pte[PTE_W-1 -: FRAME_W];
  assign present    = pte[VALID_BIT];
  assign writable   = pte[WRITE_BIT];
  assign pte_unused = ^pte;

  always_comb begin
    if (!present) begin
      status_n = XS_PAGE_FAULT;
      paddr_n  = '0;
    end else if (is_write && !writable) begin
      status_n = XS_PROT_FAULT;
      paddr_n  = '0;
    end else begin
      status_n = XS_OK;
      paddr_n  = {frame, off};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_paddr  <= '0;
      rsp_status <= XS_OK;
    end else if (load) begin
      rsp_valid  <= 1'b1;
      rsp_paddr  <= paddr_n;
      rsp_status <= status_n;
    end else if (rsp_valid && rsp_ready) begin
      rsp_valid  <= 1'b0;
    end
  end

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_status))); // R7
  AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status != XS_OK) |-> (rsp_paddr == '0)); // R4
  AST_STATUS_CODE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_status != 2'b11)); // R6
  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status == XS_OK) |-> (rsp_paddr[PAGE_W-1:0] == off)); // R1
endmodule

// File: rtl/pt_xlate.sv
module pt_xlate #(
  parameter int ADDR_W    = 32,
  parameter int PAGE_W    = 12,
  parameter int PTE_W     = 32,
  parameter int VALID_BIT = 0,
  parameter int WRITE_BIT = 1,
  parameter logic [ADDR_W-1:0] RESET_BASE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              base_we,
  input  logic [ADDR_W-1:0] base_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic              req_write,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic [1:0]        rsp_status,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [PTE_W-1:0]  mem_rdata
);
  localparam int ENTRY_SHIFT = $clog2(PTE_W / 8);

  logic [ADDR_W-1:0] table_base;
  logic              result_load;
  logic [PAGE_W-1:0] off_q;
  logic              write_q;
  logic              rsp_fire;

  assign rsp_fire = rsp_valid && rsp_ready;

  ptx_base_reg #(.ADDR_W(ADDR_W), .RESET_BASE(RESET_BASE)) base_i (
    .clk(clk), .rst(rst), .wr_en(base_we), .wr_data(base_wdata), .base_o(table_base)
  );

  ptx_fetch_ctl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .ENTRY_SHIFT(ENTRY_SHIFT)) ctl_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write), .req_vaddr(req_vaddr), .req_ready(req_ready),
    .table_base(table_base),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .rsp_fire(rsp_fire), .result_load(result_load), .off_q(off_q), .write_q(write_q)
  );

  ptx_entry_eval #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .PTE_W(PTE_W),
                   .VALID_BIT(VALID_BIT), .WRITE_BIT(WRITE_BIT)) eval_i (
    .clk(clk), .rst(rst), .load(result_load), .pte(mem_rdata), .off(off_q),
    .is_write(write_q), .rsp_ready(rsp_ready),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_status(rsp_status)
  );

  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid || mem_req) |-> !req_ready); // R7
endmodule

// File: tb/pt_xlate_tb_top.sv
module pt_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        base_we = 1'b0;
  logic [31:0] base_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_status;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  int total = 0;
  int bad = 0;
  int lat = 0;
  int pulses = 0;
  logic [31:0] cur_base = '0;

  always #4 clk = ~clk;

  pt_xlate dut_i (
    .clk(clk), .rst(rst), .base_we(base_we), .base_wdata(base_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_status(rsp_status),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  // Table contents are a fixed function of the entry address; bits 11:2 are junk.
  function automatic logic [31:0] pte_of(input logic [31:0] a);
    logic [19:0] fr;
    fr = a[21:2] * 20'd37 + 20'h001F3;
    return {fr, ~a[11:2], a[3] ^ a[6], (a[5:2] != 4'd0)};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // Memory model: answers each strobe after lat cycles.
  initial begin
    int cnt;
    bit pend;
    logic [31:0] maddr;
    cnt = 0; pend = 0; maddr = '0;
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      if (mem_req) begin
        pulses++;
        pend = 1;
        cnt = lat;
        maddr = mem_addr;
      end
      if (pend) begin
        if (cnt == 0) begin
          mem_rvalid = 1'b1;
          mem_rdata = pte_of(maddr);
          pend = 0;
        end else cnt--;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic write_base(input logic [31:0] nb);
    @(negedge clk);
    base_we = 1'b1; base_wdata = nb;
    @(negedge clk);
    base_we = 1'b0;
    cur_base = nb;
  endtask

  task automatic translate(input logic [31:0] va, input logic wr, input int stall,
                           input bit mid_wr, input logic [31:0] nb, input string areq);
    logic [31:0] ea, pte, exp_pa, held_pa;
    logic [1:0]  exp_st;
    string       sreq;
    int          p0;
    ea  = cur_base + {va[31:12], 2'b00};
    pte = pte_of(ea);
    if (!pte[0]) begin
      exp_st = 2'b01; exp_pa = '0; sreq = wr ? "R10" : "R4";
    end else if (wr && !pte[1]) begin
      exp_st = 2'b10; exp_pa = '0; sreq = "R5";
    end else begin
      exp_st = 2'b00; exp_pa = {pte[31:12], va[11:0]}; sreq = "R6";
    end
    @(negedge clk);
    chk("R7", "ready when idle", req_ready, 1);
    p0 = pulses;
    req_vaddr = va; req_write = wr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R7", "ready low in flight", req_ready, 0);
    chk("R9", "strobe after accept", mem_req, 1);
    chk(areq, "entry address", mem_addr, ea);
    if (mid_wr) begin
      base_we = 1'b1; base_wdata = nb;
    end
    @(negedge clk);
    base_we = 1'b0;
    if (mid_wr) cur_base = nb;
    while (!rsp_valid) @(negedge clk);
    chk(sreq, "status", rsp_status, exp_st);
    if (exp_st == 2'b00) begin
      chk("R1", "offset", rsp_paddr[11:0], exp_pa[11:0]);
      chk("R3", "frame", rsp_paddr[31:12], exp_pa[31:12]);
    end else begin
      chk("R4", "fault paddr zero", rsp_paddr, 0);
    end
    held_pa = rsp_paddr;
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk("R7", "held valid", rsp_valid, 1);
      chk("R7", "held paddr", rsp_paddr, held_pa);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R7", "valid drops on take", rsp_valid, 0);
    chk("R7", "ready back", req_ready, 1);
    chk("R9", "one strobe", pulses - p0, 1);
  endtask

  initial begin
    logic [31:0] bases [3];
    bases[0] = 32'h0000_0000;
    bases[1] = 32'h0040_0000;
    bases[2] = 32'hFFFF_F000;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R7", "reset req_ready", req_ready, 1);
    chk("R7", "reset rsp_valid", rsp_valid, 0);
    chk("R9", "reset mem_req", mem_req, 0);
    // First request with no base write relies on the reset base of zero.
    lat = 1;
    translate(32'h0000_3ABC, 1'b0, 0, 0, 0, "R8");
    for (int b = 0; b < 3; b++) begin
      if (b > 0) write_base(bases[b]);
      for (int i = 0; i < 40; i++) begin
        logic [19:0] vpn;
        logic [11:0] off;
        vpn = (i == 0) ? 20'h0 : (i == 39) ? 20'hFFFFF : (20'(i) * 20'h02A5D + 20'(i));
        off = (i == 1) ? 12'h000 : (i == 2) ? 12'hFFF : 12'(i * 97);
        lat = i % 4;
        for (int w = 0; w < 2; w++)
          translate({vpn, off}, w[0], i % 3, 0, 0, "R2");
      end
    end
    // Base write while the entry fetch is outstanding.
    lat = 3;
    translate(32'h0012_3456, 1'b0, 1, 1, 32'h1234_5000, "R8");
    lat = 0;
    translate(32'h0012_3456, 1'b1, 0, 0, 0, "R8");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule